// File: doc/BRIEF.md
# Virtual Interrupt List Register File

This block holds, for every physical CPU, a bank of list registers that describe the virtual interrupts a hypervisor has injected into a guest. Each entry is a 32-bit word. It carries a virtual ID, a physical ID, a priority, a two-bit state, a group-1 flag and a hardware-link flag. Software writes and reads entries by CPU and index. A CPU index at or above the number of physical CPUs names a virtual CPU, and it selects the bank of the physical CPU it shadows.

The guest side presents a virtual interrupt ID and a command against one CPU's bank. The block searches that bank combinationally. It reports the first valid entry with that ID, that entry's decoded priority, group, hardware flag and state, and whether an end-of-interrupt for that ID would be legal. An acknowledge command moves the matched entry from pending to active. A deactivate command clears its active bit.

When the deactivated entry is hardware-linked, the block raises a one-cycle request toward the physical distributor. That request carries the entry's physical ID and the physical CPU. It is filtered by ID range and, when security extensions are on, by the physical interrupt's group. The group is supplied by the distributor through a combinational query port.

Top module: `lr_file`

## Requirements
- R1: After reset every entry of every bank reads as zero, no lookup hits, and the forward request output is low.
- R2: A write stores the data with bits [22:20] forced to zero. Reads return the stored entry. Field layout: virtual ID [9:0], physical ID [19:10], priority [27:23], state [29:28], group-1 flag [30], hardware flag [31].
- R3: A CPU index c with c >= NCPU addresses the same bank as physical CPU c-NCPU. This holds for writes, reads and lookups.
- R4: A lookup reports a hit when an entry has the requested virtual ID and a state other than 0. It reports the lowest such index and that entry's state. State codes are 0 invalid, 1 pending, 2 active, 3 active+pending.
- R5: On a hit, the priority output is the 5-bit priority field shifted left by three into 8 bits. The group and hardware outputs are bits 30 and 31 of the matched entry.
- R6: eoi_ok is high exactly when some entry in the bank has the requested virtual ID and state bit 1 set. That entry need not be the first valid match.
- R7: Acknowledge (req_cmd = 1) with a hit clears bit 28 and sets bit 29 of the matched entry at the next clock edge. Without a hit, no entry changes.
- R8: Deactivate (req_cmd = 2) with a hit clears bit 29 of the matched entry at the next clock edge. Without a hit, no entry changes.
- R9: Deactivate of a matched entry whose hardware flag is set raises fwd_valid for exactly the following cycle. fwd_pid carries bits [19:10] of the entry and fwd_cpu carries the physical CPU. Entries without the flag never forward.
- R10: The forward is dropped when the physical ID is below 16 or at or above MAX_IRQ.
- R11: When sec_en is high, the forward is issued only if grpq_is_g1 is high. grpq_pid and grpq_cpu present the matched entry's physical ID and physical CPU. When sec_en is low, the group is ignored.
- R12: When a write and a command hit the same entry in the same cycle, the written value is what is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_cpu | input | CPU_W | CPU index (physical or virtual) for the write |
| wr_idx | input | IDX_W | Entry index for the write |
| wr_data | input | 32 | Entry value to write |
| rd_cpu | input | CPU_W | CPU index for the read |
| rd_idx | input | IDX_W | Entry index for the read |
| rd_data | output | 32 | Stored entry |
| req_cpu | input | CPU_W | CPU index for lookup and command |
| req_vid | input | 10 | Virtual interrupt ID to look up |
| req_cmd | input | 2 | 0 none, 1 acknowledge, 2 deactivate |
| look_hit | output | 1 | A valid entry matches |
| look_idx | output | IDX_W | Lowest matching index |
| look_state | output | 2 | State of the matched entry |
| look_prio | output | 8 | Priority of the matched entry, scaled to 8 bits |
| look_grp1 | output | 1 | Group-1 flag of the matched entry |
| look_hw | output | 1 | Hardware flag of the matched entry |
| eoi_ok | output | 1 | An active entry matches the ID |
| sec_en | input | 1 | Security extensions enabled |
| grpq_pid | output | 10 | Physical ID whose group is queried |
| grpq_cpu | output | PCPU_W | Physical CPU for the group query |
| grpq_is_g1 | input | 1 | Distributor answer: that interrupt is group 1 |
| fwd_valid | output | 1 | Deactivate request to the distributor |
| fwd_pid | output | 10 | Physical ID to deactivate |
| fwd_cpu | output | PCPU_W | Physical CPU of the request |

## Verification
The assertions check the forward path on every cycle:
- a request only ever follows a deactivate that hit a hardware-linked entry;
- the request's ID is always inside the legal range;
- the request is suppressed under security when the queried group is 0;
- every reported hit carries a non-invalid state, and eoi_ok never rises without a hit.

The stored contents can only be shown by the bench's scenarios. These cover the write masking, aliasing of virtual CPUs onto their bank, lowest-index resolution of duplicate IDs, the state transitions of acknowledge and deactivate, the unchanged entries after a miss, and a write winning over a simultaneous command.

// File: rtl/lr_pkg.sv
package lr_pkg;

    localparam int LR_W   = 32;
    localparam int ID_W   = 10;
    localparam int PRIO_W = 5;

    // bits [22:20] are reserved and never stored
    localparam logic [LR_W-1:0] LR_KEEP_MASK = 32'hFF8F_FFFF;

    localparam int MIN_FWD_PID = 16;

    typedef enum logic [1:0] {
        ST_INV     = 2'd0,
        ST_PEND    = 2'd1,
        ST_ACT     = 2'd2,
        ST_ACTPEND = 2'd3
    } lr_state_e;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_ACK   = 2'd1,
        CMD_DEACT = 2'd2,
        CMD_RSVD  = 2'd3
    } lr_cmd_e;

    function automatic logic [ID_W-1:0] f_vid(input logic [LR_W-1:0] e);
        return e[9:0];
    endfunction

    function automatic logic [ID_W-1:0] f_pid(input logic [LR_W-1:0] e);
        return e[19:10];
    endfunction

    function automatic logic [1:0] f_state(input logic [LR_W-1:0] e);
        return e[29:28];
    endfunction

    function automatic logic [7:0] f_prio8(input logic [LR_W-1:0] e);
        return {e[27:23], 3'b000};
    endfunction

    function automatic logic f_g1(input logic [LR_W-1:0] e);
        return e[30];
    endfunction

    function automatic logic f_hw(input logic [LR_W-1:0] e);
        return e[31];
    endfunction

endpackage

// File: rtl/lr_bank_map.sv
module lr_bank_map #(
    parameter int NCPU   = 2,
    parameter int CPU_W  = 2,
    parameter int PCPU_W = 1
) (
    input  logic [CPU_W-1:0]  cpu_i,
    output logic [PCPU_W-1:0] bank_o
);
    localparam logic [CPU_W-1:0] NCPU_C = CPU_W'(NCPU);

    logic [CPU_W-1:0] adj;

    always_comb begin
        adj    = (cpu_i >= NCPU_C) ? (cpu_i - NCPU_C) : cpu_i;
        bank_o = PCPU_W'(adj);
    end
endmodule

// File: rtl/lr_match.sv
module lr_match
    import lr_pkg::*;
#(
    parameter int NLR   = 4,
    parameter int IDX_W = 2
) (
    input  logic [NLR-1:0][LR_W-1:0] bank_i,
    input  logic [ID_W-1:0]          vid_i,
    output logic                     vhit_o,
    output logic [IDX_W-1:0]         vidx_o,
    output logic                     ahit_o
);
    logic [NLR-1:0] vmatch;
    logic [NLR-1:0] amatch;

    for (genvar g = 0; g < NLR; g++) begin : g_cmp
        logic id_eq;
        assign id_eq     = (f_vid(bank_i[g]) == vid_i);
        assign vmatch[g] = id_eq && (f_state(bank_i[g]) != ST_INV);
        assign amatch[g] = id_eq && f_state(bank_i[g])[1];
    end

    // lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        vhit_o = 1'b0;
        vidx_o = '0;
        for (int i = NLR - 1; i >= 0; i--) begin
            if (vmatch[i]) begin
                vhit_o = 1'b1;
                vidx_o = IDX_W'(i);
            end
        end
        ahit_o = |amatch;
    end
endmodule

// File: rtl/lr_fwd_gate.sv
module lr_fwd_gate
    import lr_pkg::*;
#(
    parameter int MAX_IRQ = 1020
) (
    input  logic            deact_hit_i,
    input  logic            hw_i,
    input  logic [ID_W-1:0] pid_i,
    input  logic            sec_en_i,
    input  logic            g1_i,
    output logic            issue_o
);
    logic in_range;
    logic sec_ok;

    always_comb begin
        in_range = (pid_i >= ID_W'(MIN_FWD_PID)) &&
                   ({1'b0, pid_i} < (ID_W+1)'(MAX_IRQ));
        sec_ok   = !sec_en_i || g1_i;
        issue_o  = deact_hit_i && hw_i && in_range && sec_ok;
    end
endmodule

// File: rtl/lr_file.sv
module lr_file
    import lr_pkg::*;
#(
    parameter int NCPU    = 2,
    parameter int NLR     = 4,
    parameter int MAX_IRQ = 1020,
    localparam int CPU_W  = $clog2(2 * NCPU),
    localparam int PCPU_W = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int IDX_W  = (NLR > 1) ? $clog2(NLR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CPU_W-1:0]  wr_cpu,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [31:0]       wr_data,
    input  logic [CPU_W-1:0]  rd_cpu,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [31:0]       rd_data,
    input  logic [CPU_W-1:0]  req_cpu,
    input  logic [9:0]        req_vid,
    input  logic [1:0]        req_cmd,
    output logic              look_hit,
    output logic [IDX_W-1:0]  look_idx,
    output logic [1:0]        look_state,
    output logic [7:0]        look_prio,
    output logic              look_grp1,
    output logic              look_hw,
    output logic              eoi_ok,
    input  logic              sec_en,
    output logic [9:0]        grpq_pid,
    output logic [PCPU_W-1:0] grpq_cpu,
    input  logic              grpq_is_g1,
    output logic              fwd_valid,
    output logic [9:0]        fwd_pid,
    output logic [PCPU_W-1:0] fwd_cpu
);

    typedef struct packed {
        logic [NCPU-1:0][NLR-1:0][LR_W-1:0] ent;
        logic                               fwd_v;
        logic [ID_W-1:0]                    fwd_pid;
        logic [PCPU_W-1:0]                  fwd_cpu;
    } st_t;

    st_t st_d, st_q;

    logic [PCPU_W-1:0] wr_bank, rd_bank, req_bank;

    lr_bank_map #(.NCPU(NCPU), .CPU_W(CPU_W), .PCPU_W(PCPU_W)) u_map_wr (
        .cpu_i (wr_cpu),
        .bank_o(wr_bank)
    );
    lr_bank_map #(.NCPU(NCPU), .CPU_W(CPU_W), .PCPU_W(PCPU_W)) u_map_rd (
        .cpu_i (rd_cpu),
        .bank_o(rd_bank)
    );
    lr_bank_map #(.NCPU(NCPU), .CPU_W(CPU_W), .PCPU_W(PCPU_W)) u_map_req (
        .cpu_i (req_cpu),
        .bank_o(req_bank)
    );

    logic [NLR-1:0][LR_W-1:0] req_bank_ent;
    logic                     m_vhit;
    logic [IDX_W-1:0]         m_vidx;
    logic                     m_ahit;

    assign req_bank_ent = st_q.ent[req_bank];

    lr_match #(.NLR(NLR), .IDX_W(IDX_W)) u_match (
        .bank_i(req_bank_ent),
        .vid_i (req_vid),
        .vhit_o(m_vhit),
        .vidx_o(m_vidx),
        .ahit_o(m_ahit)
    );

    logic [LR_W-1:0] hit_word;
    logic            deact_hit;
    logic            fwd_issue;

    assign hit_word  = m_vhit ? req_bank_ent[m_vidx] : '0;
    assign deact_hit = (req_cmd == CMD_DEACT) && m_vhit;

    lr_fwd_gate #(.MAX_IRQ(MAX_IRQ)) u_gate (
        .deact_hit_i(deact_hit),
        .hw_i       (f_hw(hit_word)),
        .pid_i      (f_pid(hit_word)),
        .sec_en_i   (sec_en),
        .g1_i       (grpq_is_g1),
        .issue_o    (fwd_issue)
    );

    // next-state computation
    always_comb begin
        st_d       = st_q;
        st_d.fwd_v = 1'b0;

        if ((req_cmd == CMD_ACK) && m_vhit) begin
            st_d.ent[req_bank][m_vidx][28] = 1'b0;
            st_d.ent[req_bank][m_vidx][29] = 1'b1;
        end

        if (deact_hit) begin
            st_d.ent[req_bank][m_vidx][29] = 1'b0;
            if (fwd_issue) begin
                st_d.fwd_v   = 1'b1;
                st_d.fwd_pid = f_pid(hit_word);
                st_d.fwd_cpu = req_bank;
            end
        end

        // a write lands last so it overrides a command on the same entry
        if (wr_en && (int'(wr_idx) < NLR)) begin
            st_d.ent[wr_bank][wr_idx] = wr_data & LR_KEEP_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data    = (int'(rd_idx) < NLR) ? st_q.ent[rd_bank][rd_idx] : '0;
        look_hit   = m_vhit;
        look_idx   = m_vidx;
        look_state = f_state(hit_word);
        look_prio  = m_vhit ? f_prio8(hit_word) : 8'h00;
        look_grp1  = f_g1(hit_word);
        look_hw    = f_hw(hit_word);
        eoi_ok     = m_ahit;
        grpq_pid   = f_pid(hit_word);
        grpq_cpu   = req_bank;
        fwd_valid  = st_q.fwd_v;
        fwd_pid    = st_q.fwd_pid;
        fwd_cpu    = st_q.fwd_cpu;
    end

endmodule

// File: rtl/lr_file_chk.sv
module lr_file_chk
    import lr_pkg::*;
#(
    parameter int MAX_IRQ = 1020
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] req_cmd,
    input logic       look_hit,
    input logic [1:0] look_state,
    input logic       look_hw,
    input logic       eoi_ok,
    input logic       sec_en,
    input logic       grpq_is_g1,
    input logic       fwd_valid,
    input logic [9:0] fwd_pid
);

    assert_fwd_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (fwd_pid >= 10'd16) && ({1'b0, fwd_pid} < 11'(MAX_IRQ)));

    assert_fwd_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> $past((req_cmd == CMD_DEACT) && look_hit && look_hw));

    assert_no_fwd_soft_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_cmd == CMD_DEACT) && look_hit && !look_hw) |=> !fwd_valid);

    assert_sec_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_cmd == CMD_DEACT) && sec_en && !grpq_is_g1) |=> !fwd_valid);

    assert_hit_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        look_hit |-> (look_state != ST_INV));

    assert_eoi_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_ok |-> look_hit);

endmodule

bind lr_file lr_file_chk #(.MAX_IRQ(MAX_IRQ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_cmd   (req_cmd),
    .look_hit  (look_hit),
    .look_state(look_state),
    .look_hw   (look_hw),
    .eoi_ok    (eoi_ok),
    .sec_en    (sec_en),
    .grpq_is_g1(grpq_is_g1),
    .fwd_valid (fwd_valid),
    .fwd_pid   (fwd_pid)
);

// File: tb/lr_file_tb.sv
module lr_file_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCPU = 2, NLR = 4, MAX_IRQ = 1020;
    localparam int CPU_W = 2, PCPU_W = 1, IDX_W = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [CPU_W-1:0] wr_cpu = '0, rd_cpu = '0, req_cpu = '0;
    logic [IDX_W-1:0] wr_idx = '0, rd_idx = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic [9:0] req_vid = '0;
    logic [1:0] req_cmd = 2'd0;
    logic look_hit, look_grp1, look_hw, eoi_ok, fwd_valid;
    logic [IDX_W-1:0] look_idx;
    logic [1:0] look_state;
    logic [7:0] look_prio;
    logic sec_en = 1'b0, grpq_is_g1 = 1'b0;
    logic [9:0] grpq_pid, fwd_pid;
    logic [PCPU_W-1:0] grpq_cpu, fwd_cpu;

    always #(CLK_PERIOD/2) clk = ~clk;

    lr_file #(.NCPU(NCPU), .NLR(NLR), .MAX_IRQ(MAX_IRQ)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cpu(wr_cpu), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_cpu(rd_cpu), .rd_idx(rd_idx), .rd_data(rd_data),
        .req_cpu(req_cpu), .req_vid(req_vid), .req_cmd(req_cmd),
        .look_hit(look_hit), .look_idx(look_idx), .look_state(look_state),
        .look_prio(look_prio), .look_grp1(look_grp1), .look_hw(look_hw),
        .eoi_ok(eoi_ok), .sec_en(sec_en), .grpq_pid(grpq_pid), .grpq_cpu(grpq_cpu),
        .grpq_is_g1(grpq_is_g1), .fwd_valid(fwd_valid), .fwd_pid(fwd_pid),
        .fwd_cpu(fwd_cpu)
    );

    typedef enum int {
        O_RD, O_HIT, O_IDX, O_PRIO, O_EOI, O_FWDV, O_FWDP, O_FWDC,
        O_STATE, O_G1, O_HW, O_GQP
    } obs_e;

    typedef struct {
        obs_e        sel;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb[$];
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    function automatic logic [31:0] observe(obs_e s);
        case (s)
            O_RD:    return rd_data;
            O_HIT:   return 32'(look_hit);
            O_IDX:   return 32'(look_idx);
            O_PRIO:  return 32'(look_prio);
            O_EOI:   return 32'(eoi_ok);
            O_FWDV:  return 32'(fwd_valid);
            O_FWDP:  return 32'(fwd_pid);
            O_FWDC:  return 32'(fwd_cpu);
            O_STATE: return 32'(look_state);
            O_G1:    return 32'(look_grp1);
            O_HW:    return 32'(look_hw);
            default: return 32'(grpq_pid);
        endcase
    endfunction

    // monitor: compares every queued expectation at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            sb_item_t it;
            logic [31:0] got;
            it  = sb.pop_front();
            got = observe(it.sel);
            n_cmp++;
            if (got !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.tag, got, it.exp);
            end
        end
    end

    function automatic logic [31:0] mk(int vid, int pid, int prio, int st, bit g1, bit hw);
        return {hw, g1, 2'(st), 5'(prio), 3'b000, 10'(pid), 10'(vid)};
    endfunction

    task automatic expect_o(obs_e s, logic [31:0] e, string tag);
        sb_item_t it;
        it.sel = s; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic flush();
        @(negedge clk); #1;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic do_write(int cpu, int idx, logic [31:0] d);
        wr_en = 1'b1; wr_cpu = CPU_W'(cpu); wr_idx = IDX_W'(idx); wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic do_cmd(int cmd, int cpu, int vid);
        req_cmd = 2'(cmd); req_cpu = CPU_W'(cpu); req_vid = 10'(vid);
        step();
        req_cmd = 2'd0;
    endtask

    task automatic chk_rd(int cpu, int idx, logic [31:0] e, string tag);
        rd_cpu = CPU_W'(cpu); rd_idx = IDX_W'(idx);
        expect_o(O_RD, e, tag);
        flush();
    endtask

    task automatic look(int cpu, int vid);
        req_cpu = CPU_W'(cpu); req_vid = 10'(vid);
    endtask

    // HW entry deactivated; returns with the forward visible
    task automatic hw_deact(int pid, bit g1);
        do_write(0, 2, mk(95, pid, 0, 2, g1, 1'b1));
        do_cmd(2, 0, 95);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        flush();

        // R1 reset state
        chk_rd(0, 0, 32'h0, "R1 reset entry cpu0/0");
        chk_rd(1, 3, 32'h0, "R1 reset entry cpu1/3");
        look(0, 0);
        expect_o(O_HIT, 0, "R1 reset no hit");
        expect_o(O_FWDV, 0, "R1 reset no forward");
        flush();

        // R2 masking
        do_write(0, 2, 32'hFFFF_FFFF);
        chk_rd(0, 2, 32'hFF8F_FFFF, "R2 reserved bits dropped");
        do_write(0, 2, 32'h0);

        // R3 virtual alias
        do_write(3, 1, mk(7, 33, 4, 1, 1'b0, 1'b0));
        chk_rd(1, 1, mk(7, 33, 4, 1, 1'b0, 1'b0), "R3 write via vcpu3 -> bank1");
        chk_rd(3, 1, mk(7, 33, 4, 1, 1'b0, 1'b0), "R3 read via vcpu3");

        // R4/R5/R6 duplicates and first match
        do_write(0, 0, mk(40, 1, 1, 0, 1'b0, 1'b0));
        do_write(0, 1, mk(40, 50, 5'h0A, 1, 1'b1, 1'b0));
        do_write(0, 3, mk(40, 60, 3, 2, 1'b0, 1'b0));
        look(0, 40);
        expect_o(O_HIT, 1, "R4 duplicate hit");
        expect_o(O_IDX, 1, "R4 lowest valid index");
        expect_o(O_STATE, 1, "R4 state of match");
        expect_o(O_PRIO, 32'h50, "R5 priority shifted");
        expect_o(O_G1, 1, "R5 group flag");
        expect_o(O_HW, 0, "R5 hw flag");
        expect_o(O_EOI, 1, "R6 active later entry validates");
        flush();
        look(2, 40);
        expect_o(O_IDX, 1, "R3 lookup via vcpu2");
        flush();
        look(0, 41);
        expect_o(O_HIT, 0, "R4 absent id");
        expect_o(O_EOI, 0, "R6 absent id");
        flush();
        look(1, 7);
        expect_o(O_EOI, 0, "R6 pending only not valid for eoi");
        flush();

        // R7 acknowledge
        do_cmd(1, 0, 40);
        chk_rd(0, 1, mk(40, 50, 5'h0A, 2, 1'b1, 1'b0), "R7 ack pending->active");
        chk_rd(0, 3, mk(40, 60, 3, 2, 1'b0, 1'b0), "R7 other duplicate unchanged");
        do_cmd(1, 0, 41);
        chk_rd(0, 0, mk(40, 1, 1, 0, 1'b0, 1'b0), "R7 miss leaves idx0");
        chk_rd(0, 1, mk(40, 50, 5'h0A, 2, 1'b1, 1'b0), "R7 miss leaves idx1");
        do_write(1, 0, mk(70, 0, 0, 3, 1'b0, 1'b0));
        do_cmd(1, 1, 70);
        chk_rd(1, 0, mk(70, 0, 0, 2, 1'b0, 1'b0), "R7 ack active+pending->active");

        // R8 deactivate, soft entry
        do_cmd(2, 0, 40);
        expect_o(O_FWDV, 0, "R9 no forward for soft entry");
        flush();
        chk_rd(0, 1, mk(40, 50, 5'h0A, 0, 1'b1, 1'b0), "R8 deactivate clears active");
        look(0, 40);
        expect_o(O_IDX, 3, "R4 next valid after deactivate");
        flush();
        do_cmd(2, 0, 44);
        chk_rd(0, 3, mk(40, 60, 3, 2, 1'b0, 1'b0), "R8 miss leaves entry");

        // R9 hardware forward via virtual cpu
        do_write(1, 2, mk(90, 200, 0, 2, 1'b0, 1'b1));
        do_cmd(2, 3, 90);
        expect_o(O_FWDV, 1, "R9 forward raised");
        expect_o(O_FWDP, 200, "R9 forward pid");
        expect_o(O_FWDC, 1, "R9 forward physical cpu");
        flush();
        chk_rd(1, 2, mk(90, 200, 0, 0, 1'b0, 1'b1), "R8 hw entry deactivated");
        step();
        expect_o(O_FWDV, 0, "R9 single-cycle pulse");
        flush();

        // R10 range filter
        hw_deact(15, 1'b0);
        expect_o(O_FWDV, 0, "R10 pid 15 dropped");
        flush();
        hw_deact(16, 1'b0);
        expect_o(O_FWDV, 1, "R10 pid 16 forwarded");
        expect_o(O_FWDP, 16, "R10 pid 16 value");
        flush();
        hw_deact(1019, 1'b0);
        expect_o(O_FWDV, 1, "R10 pid 1019 forwarded");
        flush();
        hw_deact(1020, 1'b0);
        expect_o(O_FWDV, 0, "R10 pid MAX_IRQ dropped");
        flush();

        // R11 security gate
        sec_en = 1'b1; grpq_is_g1 = 1'b0;
        do_write(0, 2, mk(95, 300, 0, 2, 1'b0, 1'b1));
        look(0, 95);
        expect_o(O_GQP, 300, "R11 group query pid");
        flush();
        do_cmd(2, 0, 95);
        expect_o(O_FWDV, 0, "R11 group0 blocked under security");
        flush();
        grpq_is_g1 = 1'b1;
        hw_deact(300, 1'b0);
        expect_o(O_FWDV, 1, "R11 group1 forwarded under security");
        expect_o(O_FWDC, 0, "R11 forward cpu");
        flush();
        sec_en = 1'b0; grpq_is_g1 = 1'b0;
        hw_deact(301, 1'b0);
        expect_o(O_FWDV, 1, "R11 group ignored without security");
        flush();

        // R12 write beats command
        do_write(0, 2, mk(93, 0, 1, 1, 1'b0, 1'b0));
        req_cmd = 2'd1; req_cpu = 2'd0; req_vid = 10'd93;
        wr_en = 1'b1; wr_cpu = 2'd0; wr_idx = 2'd2; wr_data = mk(93, 0, 7, 1, 1'b0, 1'b0);
        step();
        req_cmd = 2'd0; wr_en = 1'b0;
        chk_rd(0, 2, mk(93, 0, 7, 1, 1'b0, 1'b0), "R12 write wins over ack");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule